// File: doc/BRIEF.md
# Volume Envelope with Rewrite Glitch

The block keeps the 4-bit volume of one tone channel. An 8-bit configuration word sets it up. Bits 7:4 hold the starting volume, bit 3 the direction (1 = rise, 0 = fall) and bits 2:0 the step period. A trigger restarts the envelope from that word.

A pulse on the envelope strobe starts a three-phase step sequence. The phases run on three consecutive cycles:

- **Count-down:** the period timer drops by one.
- **Arm:** on expiry, the timer reloads and a pending-step flag is set.
- **Apply:** the volume moves one unit, unless a lock holds it at its end value.

Rewriting the configuration while the channel plays changes the volume at once, through a fixed set of increment and inversion rules. The outputs are the volume and a one-cycle pulse that marks every change of it.

The step sequencer is a four-state machine:

- **PH_IDLE** moves to **PH_DEC** on a strobe.
- **PH_DEC** always moves to **PH_ARM**.
- **PH_ARM** always moves to **PH_APPLY**.
- **PH_APPLY** moves to **PH_DEC** if a new strobe is present, and to **PH_IDLE** otherwise.
- A trigger sends every state back to **PH_IDLE** (abort).

Top module: `vol_envelope`

## Requirements
- R1: After reset the volume is 0, the change pulse is 0 and the stored configuration is 0.
- R2: A trigger loads the volume from config bits 7:4 and the timer from bits 2:0. It clears the pending-step flag and the lock, and aborts a running step sequence.
- R3: A strobe runs count-down, arm and apply on the three following clock edges, so a step is visible three cycles after the strobe edge. Count-down lowers a nonzero timer by one only when the period is nonzero; with period 0 the volume never steps.
- R4: Arm acts only when the channel is active, the period is nonzero and the timer is 0. It then reloads the timer with the period and sets the pending-step flag.
- R5: Apply with the flag set clears the flag. If the envelope is unlocked, apply moves the volume by 1, saturating at 15 when rising and at 0 when falling, and locks the envelope when the new volume is 15 (rising) or 0 (falling). A locked envelope ignores apply and the write tick.
- R6: A configuration write while the channel is inactive only stores the word; the volume is unchanged.
- R7: A write while the channel is active makes a tick pending in two cases, provided the envelope is unlocked. The first is an old period of 0 and a new period that is nonzero. The second is old and new low nibbles both equal to 0x8. A tick adds or subtracts 1 modulo 16 in the new direction.
- R8: A write that switches the direction to rising sets the volume to volume XOR 0xF when the old period was 0 and the envelope is unlocked. Otherwise it sets the volume to (14 - volume) mod 16. Either way the pending tick is cancelled. A switch to falling sets the volume to (16 - volume) mod 16 and keeps the tick.
- R9: A write while active with the step flag set reloads the timer with the new period. If no tick is pending and the new period is 0, the flag is cleared.
- R10: In one cycle, trigger beats write, and write beats any step phase. A phase that coincides with a write or trigger is lost, although the sequence advances. A trigger with a write uses the written word.
- R11: The change pulse is 1 for exactly the cycle in which a new volume value first appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration word: start volume 7:4, direction 3, period 2:0 |
| trigger | input | 1 | Restart the envelope |
| env_strobe | input | 1 | Envelope strobe from the frame sequencer |
| chan_active | input | 1 | Channel is currently playing |
| vol | output | 4 | Current volume |
| vol_changed | output | 1 | One-cycle pulse when the volume changes |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a configuration write and the apply phase. The bench holds the write strobe in exactly the cycle in which the sequencer sits in PH_APPLY with the step flag set. It expects the step to be lost and the glitch result alone. It then judges the timer reload, or the flag clear, by how many later strobes pass before the next step.

The second pair is a trigger and a write in one cycle. The trigger must load the freshly written start volume.

// File: rtl/venv_pkg.sv
package venv_pkg;
    parameter int unsigned VOL_W = 4;
    parameter int unsigned PER_W = 3;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DEC   = 2'd1,
        PH_ARM   = 2'd2,
        PH_APPLY = 2'd3
    } phase_e;
endpackage

// File: rtl/venv_seq.sv
module venv_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic abort,
    output logic do_dec,
    output logic do_arm,
    output logic do_apply
);
    import venv_pkg::*;

    phase_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:  state_d = strobe ? PH_DEC : PH_IDLE;
            PH_DEC:   state_d = PH_ARM;
            PH_ARM:   state_d = PH_APPLY;
            PH_APPLY: state_d = strobe ? PH_DEC : PH_IDLE;
            default:  state_d = PH_IDLE;
        endcase
        if (abort) state_d = PH_IDLE;
    end

    always_comb begin
        do_dec   = 1'b0;
        do_arm   = 1'b0;
        do_apply = 1'b0;
        unique case (state_q)
            PH_IDLE:  ;
            PH_DEC:   do_dec   = 1'b1;
            PH_ARM:   do_arm   = 1'b1;
            PH_APPLY: do_apply = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/venv_timer.sv
module venv_timer #(
    parameter int unsigned PER_W = venv_pkg::PER_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PER_W-1:0] load_val,
    input  logic             reload,
    input  logic [PER_W-1:0] reload_val,
    input  logic             dec_en,
    input  logic             arm_en,
    input  logic             active,
    input  logic [PER_W-1:0] period,
    output logic             arm_fire
);
    logic [PER_W-1:0] tmr_q;
    logic             per_nz;

    always_comb begin
        per_nz   = (period != '0);
        arm_fire = arm_en && active && per_nz && (tmr_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (load) begin
            tmr_q <= load_val;
        end else if (reload) begin
            tmr_q <= reload_val;
        end else if (dec_en && per_nz && (tmr_q != '0)) begin
            tmr_q <= tmr_q - 1'b1;
        end else if (arm_fire) begin
            tmr_q <= period;
        end
    end
endmodule

// File: rtl/venv_glitch.sv
module venv_glitch #(
    parameter int unsigned VOL_W = venv_pkg::VOL_W,
    parameter int unsigned PER_W = venv_pkg::PER_W,
    localparam int unsigned CFG_W = VOL_W + 1 + PER_W
) (
    input  logic [CFG_W-1:0] old_cfg,
    input  logic [CFG_W-1:0] new_cfg,
    input  logic [VOL_W-1:0] vol_in,
    input  logic             locked,
    input  logic             armed,
    output logic [VOL_W-1:0] vol_out,
    output logic             drop_arm
);
    localparam logic [VOL_W-1:0] VOL_TOP_M1 = VOL_W'((2 ** VOL_W) - 2);

    logic [PER_W-1:0] old_per, new_per;
    logic             old_dir, new_dir;
    logic             tick;
    logic [VOL_W-1:0] v;

    always_comb begin
        old_per = old_cfg[PER_W-1:0];
        new_per = new_cfg[PER_W-1:0];
        old_dir = old_cfg[PER_W];
        new_dir = new_cfg[PER_W];

        tick = !locked &&
               (((new_per != '0) && (old_per == '0)) ||
                (new_dir && (new_per == '0) && old_dir && (old_per == '0)));

        v = vol_in;
        if (old_dir != new_dir) begin
            if (new_dir) begin
                if ((old_per == '0) && !locked) v = vol_in ^ {VOL_W{1'b1}};
                else                            v = VOL_TOP_M1 - vol_in;
                tick = 1'b0;
            end else begin
                v = '0 - vol_in;
            end
        end

        if (tick) v = new_dir ? v + 1'b1 : v - 1'b1;

        vol_out  = v;
        drop_arm = !tick && (new_per == '0) && armed;
    end
endmodule

// File: rtl/vol_envelope.sv
module vol_envelope #(
    parameter int unsigned VOL_W = venv_pkg::VOL_W,
    parameter int unsigned PER_W = venv_pkg::PER_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr,
    input  logic [VOL_W+PER_W:0]   cfg_wdata,
    input  logic                   trigger,
    input  logic                   env_strobe,
    input  logic                   chan_active,
    output logic [VOL_W-1:0]       vol,
    output logic                   vol_changed
);
    localparam int unsigned CFG_W = VOL_W + 1 + PER_W;
    localparam logic [VOL_W-1:0] VOL_TOP = '1;

    logic [CFG_W-1:0] cfg_q, cfg_nx;
    logic [VOL_W-1:0] vol_q, vol_d, vol_step, g_vol;
    logic             armed_q, armed_d, locked_q, locked_d;
    logic             vol_chg_q, lock_hit, g_drop, arm_fire;
    logic             seq_dec, seq_arm, seq_apply;
    logic             quiet, ph_dec, ph_arm, ph_apply, wr_live;
    logic             cur_dir;

    always_comb begin
        cfg_nx   = cfg_wr ? cfg_wdata : cfg_q;
        quiet    = !trigger && !cfg_wr;
        ph_dec   = seq_dec && quiet;
        ph_arm   = seq_arm && quiet;
        ph_apply = seq_apply && quiet;
        wr_live  = cfg_wr && chan_active && !trigger;
        cur_dir  = cfg_q[PER_W];
    end

    venv_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (env_strobe),
        .abort    (trigger),
        .do_dec   (seq_dec),
        .do_arm   (seq_arm),
        .do_apply (seq_apply)
    );

    venv_timer #(.PER_W(PER_W)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (trigger),
        .load_val   (cfg_nx[PER_W-1:0]),
        .reload     (wr_live && armed_q),
        .reload_val (cfg_wdata[PER_W-1:0]),
        .dec_en     (ph_dec),
        .arm_en     (ph_arm),
        .active     (chan_active),
        .period     (cfg_q[PER_W-1:0]),
        .arm_fire   (arm_fire)
    );

    venv_glitch #(.VOL_W(VOL_W), .PER_W(PER_W)) u_glitch (
        .old_cfg  (cfg_q),
        .new_cfg  (cfg_wdata),
        .vol_in   (vol_q),
        .locked   (locked_q),
        .armed    (armed_q),
        .vol_out  (g_vol),
        .drop_arm (g_drop)
    );

    always_comb begin
        if (cur_dir) vol_step = (vol_q != VOL_TOP) ? vol_q + 1'b1 : vol_q;
        else         vol_step = (vol_q != '0)      ? vol_q - 1'b1 : vol_q;
        lock_hit = cur_dir ? (vol_step == VOL_TOP) : (vol_step == '0);
    end

    always_comb begin
        vol_d    = vol_q;
        armed_d  = armed_q;
        locked_d = locked_q;
        if (trigger) begin
            vol_d    = cfg_nx[CFG_W-1 -: VOL_W];
            armed_d  = 1'b0;
            locked_d = 1'b0;
        end else if (wr_live) begin
            vol_d = g_vol;
            if (g_drop) armed_d = 1'b0;
        end else if (ph_apply && armed_q) begin
            armed_d = 1'b0;
            if (!locked_q) begin
                vol_d    = vol_step;
                locked_d = lock_hit;
            end
        end else if (arm_fire) begin
            armed_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            vol_q     <= '0;
            armed_q   <= 1'b0;
            locked_q  <= 1'b0;
            vol_chg_q <= 1'b0;
        end else begin
            cfg_q     <= cfg_nx;
            vol_q     <= vol_d;
            armed_q   <= armed_d;
            locked_q  <= locked_d;
            vol_chg_q <= (vol_d != vol_q);
        end
    end

    assign vol         = vol_q;
    assign vol_changed = vol_chg_q;
endmodule

// File: rtl/vol_envelope_chk.sv
module vol_envelope_chk #(
    parameter int unsigned VOL_W = venv_pkg::VOL_W,
    parameter int unsigned PER_W = venv_pkg::PER_W,
    localparam int unsigned CFG_W = VOL_W + 1 + PER_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic             trigger,
    input logic             chan_active,
    input logic [VOL_W-1:0] vol,
    input logic             vol_changed,
    input logic [CFG_W-1:0] cfg_q,
    input logic             locked_q,
    input logic             seq_dec,
    input logic             seq_arm,
    input logic             seq_apply
);
    localparam logic [VOL_W-1:0] VTOP = '1;

    AST_CHANGE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        vol_changed == (vol != $past(vol))); // R11

    AST_TRIG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        trigger && !cfg_wr |=> vol == $past(cfg_q[CFG_W-1 -: VOL_W])); // R2

    AST_TRIG_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        trigger && cfg_wr |=> vol == $past(cfg_wdata[CFG_W-1 -: VOL_W])); // R10

    AST_INACTIVE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && !chan_active && !trigger |=> $stable(vol)); // R6

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q && !trigger && !(cfg_wr && chan_active) |=> $stable(vol)); // R5

    AST_STEP_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !trigger && !cfg_wr |=>
            !((($past(vol) == VTOP) && (vol == '0)) || (($past(vol) == '0) && (vol == VTOP)))); // R5

    AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({seq_dec, seq_arm, seq_apply})); // R3

    AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        seq_dec && !trigger |=> seq_arm); // R3
endmodule

bind vol_envelope vol_envelope_chk #(.VOL_W(VOL_W), .PER_W(PER_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_wdata   (cfg_wdata),
    .trigger     (trigger),
    .chan_active (chan_active),
    .vol         (vol),
    .vol_changed (vol_changed),
    .cfg_q       (cfg_q),
    .locked_q    (locked_q),
    .seq_dec     (seq_dec),
    .seq_arm     (seq_arm),
    .seq_apply   (seq_apply)
);

// File: tb/test_vol_envelope.sv
module test_vol_envelope;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;
    // {first word, rewrite word, expected volume after rewrite}
    localparam logic [19:0] VEC [NVEC] = '{
        {8'h70, 8'h71, 4'h6}, {8'h78, 8'h79, 4'h8}, {8'h71, 8'h72, 4'h7},
        {8'h78, 8'h78, 4'h8}, {8'h70, 8'h78, 4'h8}, {8'h71, 8'h79, 4'h7},
        {8'h79, 8'h71, 4'h9}, {8'h30, 8'h38, 4'hC}, {8'h58, 8'h50, 4'hB},
        {8'h28, 8'h21, 4'hD}, {8'h08, 8'h09, 4'h1}, {8'h00, 8'h01, 4'hF},
        {8'hF9, 8'hF9, 4'hF}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       trigger = 1'b0;
    logic       env_strobe = 1'b0;
    logic       chan_active = 1'b0;
    logic [3:0] vol;
    logic       vol_changed;
    int         n_tests = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vol_envelope i_vol_envelope (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_wdata   (cfg_wdata),
        .trigger     (trigger),
        .env_strobe  (env_strobe),
        .chan_active (chan_active),
        .vol         (vol),
        .vol_changed (vol_changed)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic trig();
        @(negedge clk); trigger = 1'b1;
        @(negedge clk); trigger = 1'b0;
    endtask

    task automatic strobe_run();
        @(negedge clk); env_strobe = 1'b1;
        @(negedge clk); env_strobe = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // strobe, then write during the apply-phase cycle
    task automatic strobe_with_write(input logic [7:0] v);
        @(negedge clk); env_strobe = 1'b1;
        @(negedge clk); env_strobe = 1'b0;
        @(negedge clk);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic setup(input logic [7:0] v);
        chan_active = 1'b0;
        wr(v);
        chan_active = 1'b1;
        trig();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 vol", vol, 4'h0);
        chk("R1 pulse", {3'b0, vol_changed}, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            setup(VEC[i][19:12]);
            chk("R2 trigger load", vol, VEC[i][19:16]);
            wr(VEC[i][11:4]);
            chk("R7/R8 rewrite", vol, VEC[i][3:0]);
        end

        // R3 R5 R11: one falling step
        setup(8'h71);
        strobe_run();
        chk("R3 step", vol, 4'h6);
        chk("R11 pulse", {3'b0, vol_changed}, 4'h1);
        @(negedge clk);
        chk("R11 pulse end", {3'b0, vol_changed}, 4'h0);

        // R3 period zero never steps
        setup(8'h50);
        strobe_run();
        chk("R3 period0", vol, 4'h5);

        // R4 period 2 needs two strobes
        setup(8'hA2);
        strobe_run();
        chk("R4 period2 first", vol, 4'hA);
        strobe_run();
        chk("R4 period2 second", vol, 4'h9);

        // R4 inactive channel never arms
        setup(8'h71);
        chan_active = 1'b0;
        strobe_run();
        chk("R4 inactive", vol, 4'h7);

        // R6 write while inactive leaves volume
        setup(8'h51);
        chan_active = 1'b0;
        wr(8'h59);
        chk("R6 inactive write", vol, 4'h5);
        chan_active = 1'b1;

        // R5 lock at top, ignores apply and write tick; trigger clears lock
        setup(8'hE9);
        strobe_run();
        chk("R5 rise to 15", vol, 4'hF);
        strobe_run();
        chk("R5 locked", vol, 4'hF);
        chk("R11 no pulse", {3'b0, vol_changed}, 4'h0);
        chan_active = 1'b0; wr(8'hF8); chan_active = 1'b1;
        wr(8'hF8);
        chk("R5 lock blocks tick", vol, 4'hF);
        trig();
        chk("R2 retrigger", vol, 4'hF);
        wr(8'hF8);
        chk("R2 lock cleared, R7 wrap", vol, 4'h0);

        // R9 R10 write in the apply cycle reloads timer, step lost
        setup(8'h71);
        strobe_with_write(8'h73);
        chk("R10 apply lost", vol, 4'h7);
        strobe_run();
        chk("R9 pending step", vol, 4'h6);
        strobe_run();
        chk("R9 reload a", vol, 4'h6);
        strobe_run();
        chk("R9 reload b", vol, 4'h5);

        // R9 write of period 0 drops pending flag
        setup(8'h71);
        strobe_with_write(8'h70);
        chk("R9 clear write", vol, 4'h7);
        strobe_run();
        chk("R9 flag cleared", vol, 4'h7);

        // R2 trigger aborts sequence
        setup(8'h71);
        @(negedge clk); env_strobe = 1'b1;
        @(negedge clk); env_strobe = 1'b0;
        @(negedge clk); trigger = 1'b1;
        @(negedge clk); trigger = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 abort", vol, 4'h7);

        // R10 trigger and write together use written word
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = 8'hC3; trigger = 1'b1;
        @(negedge clk); cfg_wr = 1'b0; trigger = 1'b0;
        chk("R10 trigger+write", vol, 4'hC);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule